// File: doc/BRIEF.md
# SPI Receive-Only Request Engine

This block runs the read side of an SPI master when no data is sent. A single write of a byte count starts the serial clock with the transmitter idle. Each incoming byte is shifted in MSB first and sampled on the rising clock edge. Bytes are then gathered into 32-bit receive words, whatever word width the rest of the controller is set to. Each word goes to a receive FIFO, which appears here only as a push strobe and a full input.

A remaining-byte counter falls by one for every byte that arrives. A word is handed over once four bytes are in it, or when the last requested byte arrives. A shorter final word is right-aligned, and a three-bit valid-byte count travels with every pushed word. The largest request is four bytes per FIFO entry, so one request can never overrun an empty FIFO. Larger counts are cut down to that limit.

Top module: `spi_rxo_engine`

## Requirements
- R1: A request write with a non-zero count while idle sets `busy_o` on the next clock edge and loads `todo_o` with the accepted count.
- R2: `todo_o` falls by exactly one for every received byte and never changes otherwise while busy; it reads 0 when the transfer ends.
- R3: Bytes are packed MSB first: a full word has the first received byte in bits [31:24] and the fourth in bits [7:0], and it is pushed once its fourth byte arrives.
- R4: When fewer than four bytes remain, the final word holds only those bytes, right-aligned, with the first of them at bit (v-1)*8, where v is the count. `rxbv_o` shows v (1 to 3) during that push, and shows 4 for every full word.
- R5: `sclk_o` idles low. `miso_i` is sampled on each rising edge of `sclk_o`, most significant bit of each byte first, and the clock is low again once `busy_o` falls.
- R6: A requested count above FIFO_DEPTH*4 (32 by default) is clamped to FIFO_DEPTH*4.
- R7: `busy_o` stays high until the cycle in which the last word is pushed and is low on the following cycle. A request while busy, or a request of count 0, is ignored.
- R8: If `rx_full_i` is high when a word is ready, the word is dropped with no `rx_push_o` pulse and `ovf_o` is set. `ovf_o` stays set until the next accepted request clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_wr_i | input | 1 | Request register write strobe |
| req_count_i | input | 16 | Number of bytes to receive |
| miso_i | input | 1 | Serial data from the slave |
| sclk_o | output | 1 | Serial clock |
| rx_full_i | input | 1 | Receive FIFO cannot take a word |
| rx_word_o | output | 32 | Packed receive word |
| rx_push_o | output | 1 | Push strobe for `rx_word_o` |
| rxbv_o | output | 3 | Valid bytes in the word being pushed |
| todo_o | output | 16 | Bytes still to be received |
| busy_o | output | 1 | Transfer in progress |
| ovf_o | output | 1 | Sticky receive overflow flag |

## Verification
A wrong byte-slot count inside the packer appears at the first push: the word pushes early or late, its bytes sit in the wrong lanes, or `rxbv_o` is wrong. This shows within one word time of about 32 sclk periods. A wrong remaining-byte count appears at once on `todo_o`. It also shows as a wrong number of pushes, or a `busy_o` that never falls, by the end of the request. An error in the bit sampler corrupts every word from the first push onward, so comparing whole words against a model of the slave's byte stream catches it within one transfer.

// File: rtl/spi_rxo_pkg.sv
package spi_rxo_pkg;
   localparam int BYTE_W     = 8;
   localparam int WORD_BYTES = 4;
   localparam int WORD_W     = BYTE_W * WORD_BYTES;
   localparam int CNT_W      = 16;
   localparam int BV_W       = 3;

   typedef logic [WORD_W-1:0] rx_word_t;
   typedef logic [CNT_W-1:0]  rx_cnt_t;
   typedef logic [BYTE_W-1:0] rx_byte_t;
   typedef logic [BV_W-1:0]   rx_bv_t;
endpackage

// File: rtl/spi_rxo_sclk_gen.sv
module spi_rxo_sclk_gen #(
   parameter int HALF_CYC  = 2,
   parameter bit SCLK_IDLE = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic sclk_o,
   output logic rise_o
);
   localparam int DIV_W = $clog2(HALF_CYC + 1);
   localparam logic [DIV_W-1:0] LAST = DIV_W'(HALF_CYC - 1);

   if (HALF_CYC < 2) begin : g_bad_half
      $error("HALF_CYC must be at least 2");
   end

   logic [DIV_W-1:0] div_q;
   logic             phase_q;   // 0 = idle level, 1 = active level
   logic             en;
   logic             term;

   assign en     = run_i | phase_q;
   assign term   = (div_q == LAST);
   assign rise_o = en & term & ~phase_q & run_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q   <= '0;
         phase_q <= 1'b0;
      end else if (!en) begin
         div_q   <= '0;
      end else if (term) begin
         div_q   <= '0;
         phase_q <= ~phase_q;
      end else begin
         div_q   <= div_q + 1'b1;
      end
   end

   if (SCLK_IDLE) begin : g_idle_high
      assign sclk_o = ~phase_q;
   end else begin : g_idle_low
      assign sclk_o = phase_q;
   end

   AST_RISE_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> phase_q); // R5
endmodule

// File: rtl/spi_rxo_shifter.sv
module spi_rxo_shifter
   import spi_rxo_pkg::*;
#(
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     clr_i,
   input  logic     sample_i,
   input  logic     miso_i,
   output logic     byte_vld_o,
   output rx_byte_t byte_o
);
   localparam int BIT_CW = $clog2(BYTE_W);

   logic [BIT_CW-1:0] bit_q;
   rx_byte_t          sh_q;
   rx_byte_t          sh_next;
   logic              vld_q;

   if (MSB_FIRST) begin : g_msb
      assign sh_next = {sh_q[BYTE_W-2:0], miso_i};
   end else begin : g_lsb
      assign sh_next = {miso_i, sh_q[BYTE_W-1:1]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_q <= '0;
         sh_q  <= '0;
         vld_q <= 1'b0;
      end else if (clr_i) begin
         bit_q <= '0;
         vld_q <= 1'b0;
      end else begin
         vld_q <= sample_i && (bit_q == BIT_CW'(BYTE_W - 1));
         if (sample_i) begin
            sh_q  <= sh_next;
            bit_q <= bit_q + 1'b1;
         end
      end
   end

   assign byte_vld_o = vld_q;
   assign byte_o     = sh_q;

   AST_BYTE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q |=> !vld_q); // R2
endmodule

// File: rtl/spi_rxo_packer.sv
module spi_rxo_packer
   import spi_rxo_pkg::*;
#(
   parameter int MAX_BYTES = 32
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     req_wr_i,
   input  rx_cnt_t  req_count_i,
   input  logic     byte_vld_i,
   input  rx_byte_t byte_i,
   input  logic     rx_full_i,
   output logic     accept_o,
   output logic     run_o,
   output rx_cnt_t  todo_o,
   output rx_word_t word_o,
   output logic     push_o,
   output rx_bv_t   rxbv_o,
   output logic     busy_o,
   output logic     ovf_o
);
   localparam int SLOT_W = $clog2(WORD_BYTES);
   localparam rx_cnt_t MAX_CNT = rx_cnt_t'(MAX_BYTES);
   localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(WORD_BYTES - 1);

   if (MAX_BYTES < 1 || MAX_BYTES >= (1 << CNT_W)) begin : g_bad_max
      $error("MAX_BYTES out of range for the count field");
   end

   logic              busy_q;
   rx_cnt_t           todo_q;
   logic [SLOT_W-1:0] slot_q;
   rx_word_t          word_q;
   rx_word_t          word_base;
   logic              push_q;
   rx_bv_t            rxbv_q;
   logic              ovf_q;
   logic              accept;
   logic              flush;
   rx_cnt_t           eff_cnt;

   assign accept    = req_wr_i & ~busy_q & (req_count_i != '0);
   assign eff_cnt   = (req_count_i > MAX_CNT) ? MAX_CNT : req_count_i;
   assign flush     = (slot_q == LAST_SLOT) || (todo_q == rx_cnt_t'(1));
   assign word_base = (slot_q == '0) ? '0 : word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         todo_q <= '0;
         slot_q <= '0;
         word_q <= '0;
         push_q <= 1'b0;
         rxbv_q <= '0;
         ovf_q  <= 1'b0;
      end else begin
         push_q <= 1'b0;
         if (accept) begin
            busy_q <= 1'b1;
            todo_q <= eff_cnt;
            slot_q <= '0;
            word_q <= '0;
            ovf_q  <= 1'b0;
         end else begin
            if (push_q && (todo_q == '0)) begin
               busy_q <= 1'b0;
            end
            if (push_q && rx_full_i) begin
               ovf_q <= 1'b1;
            end
            if (byte_vld_i && busy_q) begin
               todo_q <= todo_q - 1'b1;
               word_q <= {word_base[WORD_W-BYTE_W-1:0], byte_i};
               if (flush) begin
                  push_q <= 1'b1;
                  rxbv_q <= rx_bv_t'(slot_q) + 1'b1;
                  slot_q <= '0;
               end else begin
                  slot_q <= slot_q + 1'b1;
               end
            end
         end
      end
   end

   assign accept_o = accept;
   assign run_o    = busy_q & (todo_q != '0);
   assign todo_o   = todo_q;
   assign word_o   = word_q;
   assign push_o   = push_q & ~rx_full_i;
   assign rxbv_o   = rxbv_q;
   assign busy_o   = busy_q;
   assign ovf_o    = ovf_q;

   AST_TODO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !byte_vld_i) |=> (todo_q == $past(todo_q))); // R2
   AST_TODO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && byte_vld_i) |=> (todo_q == $past(todo_q) - 16'd1)); // R2
   AST_FULL_WORD_BV: assert property (@(posedge clk) disable iff (!rst_n)
      (push_q && todo_q != '0) |-> (rxbv_q == 3'd4)); // R3
   AST_BV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      push_q |-> (rxbv_q != '0 && rxbv_q <= 3'd4)); // R4
   AST_TODO_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      todo_q <= MAX_CNT); // R6
   AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
      (push_q && todo_q == '0 && !req_wr_i) |=> !busy_q); // R7
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (push_q && rx_full_i && !accept) |=> ovf_q); // R8
endmodule

// File: rtl/spi_rxo_engine.sv
module spi_rxo_engine
   import spi_rxo_pkg::*;
#(
   parameter int HALF_CYC   = 2,
   parameter int FIFO_DEPTH = 8,
   parameter bit SCLK_IDLE  = 1'b0,
   parameter bit MSB_FIRST  = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_wr_i,
   input  logic [15:0] req_count_i,
   input  logic        miso_i,
   output logic        sclk_o,
   input  logic        rx_full_i,
   output logic [31:0] rx_word_o,
   output logic        rx_push_o,
   output logic [2:0]  rxbv_o,
   output logic [15:0] todo_o,
   output logic        busy_o,
   output logic        ovf_o
);
   localparam int MAX_BYTES = FIFO_DEPTH * WORD_BYTES;

   if (FIFO_DEPTH < 1) begin : g_bad_depth
      $error("FIFO_DEPTH must be positive");
   end

   logic     accept;
   logic     run;
   logic     rise;
   logic     byte_vld;
   rx_byte_t byte_val;

   spi_rxo_sclk_gen #(
      .HALF_CYC  (HALF_CYC),
      .SCLK_IDLE (SCLK_IDLE)
   ) u_sclk (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (run),
      .sclk_o (sclk_o),
      .rise_o (rise)
   );

   spi_rxo_shifter #(
      .MSB_FIRST (MSB_FIRST)
   ) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (accept),
      .sample_i   (rise),
      .miso_i     (miso_i),
      .byte_vld_o (byte_vld),
      .byte_o     (byte_val)
   );

   spi_rxo_packer #(
      .MAX_BYTES (MAX_BYTES)
   ) u_pack (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_wr_i    (req_wr_i),
      .req_count_i (req_count_i),
      .byte_vld_i  (byte_vld),
      .byte_i      (byte_val),
      .rx_full_i   (rx_full_i),
      .accept_o    (accept),
      .run_o       (run),
      .todo_o      (todo_o),
      .word_o      (rx_word_o),
      .push_o      (rx_push_o),
      .rxbv_o      (rxbv_o),
      .busy_o      (busy_o),
      .ovf_o       (ovf_o)
   );

   AST_IDLE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (sclk_o == SCLK_IDLE)); // R5
   AST_SAMPLE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      rise |-> busy_o); // R5
   AST_START: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> busy_o); // R1
endmodule

// File: tb/spi_rxo_engine_tb_top.sv
module spi_rxo_engine_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_wr = 1'b0;
   logic [15:0] req_count = '0;
   logic        miso = 1'b0;
   logic        sclk;
   logic        rx_full = 1'b0;
   logic [31:0] rx_word;
   logic        rx_push;
   logic [2:0]  rxbv;
   logic [15:0] todo;
   logic        busy;
   logic        ovf;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   spi_rxo_engine dut_i (
      .clk(clk), .rst_n(rst_n), .req_wr_i(req_wr), .req_count_i(req_count),
      .miso_i(miso), .sclk_o(sclk), .rx_full_i(rx_full), .rx_word_o(rx_word),
      .rx_push_o(rx_push), .rxbv_o(rxbv), .todo_o(todo), .busy_o(busy), .ovf_o(ovf)
   );

   // slave model: byte stream shifted out MSB first, advanced on sclk falling
   logic [7:0] stream [0:63];
   int bitp = 0;
   always @(negedge sclk) begin
      bitp = bitp + 1;
      if (bitp < 512) miso = stream[bitp >> 3][7 - (bitp & 7)];
   end

   // push monitor and todo step monitor
   logic [31:0] got_w  [0:15];
   logic [2:0]  got_bv [0:15];
   int  ngot = 0;
   bit  todo_bad = 0;
   bit  prev_busy = 0;
   logic [15:0] prev_todo = '0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (rx_push) begin
            if (ngot < 16) begin
               got_w[ngot]  = rx_word;
               got_bv[ngot] = rxbv;
            end
            ngot = ngot + 1;
         end
         if (prev_busy && busy && todo != prev_todo && todo != prev_todo - 16'd1)
            todo_bad = 1;
         prev_busy = busy;
         prev_todo = todo;
      end
   end

   task automatic chk(bit ok, string rq, string what, longint act, longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   function automatic int clamp_cnt(int n);
      return (n > 32) ? 32 : n;
   endfunction

   function automatic int bytes_in_word(int k, int eff);
      int r = eff - 4 * k;
      return (r > 4) ? 4 : r;
   endfunction

   function automatic logic [31:0] exp_word(int k, int eff);
      logic [31:0] w = '0;
      for (int i = 0; i < bytes_in_word(k, eff); i++)
         w = (w << 8) | 32'(stream[4 * k + i]);
      return w;
   endfunction

   task automatic run_xfer(int n, bit full_mode, bit poke);
      int eff = clamp_cnt(n);
      int nw  = (eff + 3) / 4;
      int cyc = 0;
      for (int i = 0; i < 64; i++) stream[i] = 8'($urandom);
      bitp = 0;
      miso = stream[0][7];
      ngot = 0;
      todo_bad = 0;
      rx_full = full_mode;
      @(negedge clk);
      req_wr = 1'b1;
      req_count = 16'(n);
      @(negedge clk);
      req_wr = 1'b0;
      chk(busy == 1'b1, "R1", "busy after request", busy, 1);
      chk(todo == 16'(eff), "R6", "todo loaded/clamped", todo, eff);
      chk(ovf == 1'b0, "R8", "ovf cleared by request", ovf, 0);
      if (poke) begin
         repeat (10) @(negedge clk);
         req_wr = 1'b1;
         req_count = 16'd3;
         @(negedge clk);
         req_wr = 1'b0;
         chk(todo != 16'd3 && busy, "R7", "request while busy ignored", todo, eff);
      end
      while (busy && cyc < 5000) begin
         @(negedge clk);
         cyc++;
      end
      if (busy) begin
         chk(1'b0, "R7", "watchdog on busy", 1, 0);
         return;
      end
      chk(todo == 16'd0, "R2", "todo at end", todo, 0);
      chk(!todo_bad, "R2", "todo stepped by one", todo_bad, 0);
      chk(sclk == 1'b0, "R5", "sclk idle low", sclk, 0);
      chk(ovf == full_mode, "R8", "overflow flag", ovf, full_mode);
      chk(ngot == (full_mode ? 0 : nw), "R7", "push count", ngot, full_mode ? 0 : nw);
      if (!full_mode) begin
         for (int k = 0; k < nw && k < ngot; k++) begin
            chk(got_w[k] == exp_word(k, eff), (bytes_in_word(k, eff) == 4) ? "R3" : "R4",
                "word data", got_w[k], exp_word(k, eff));
            chk(got_bv[k] == 3'(bytes_in_word(k, eff)), "R4", "valid byte count",
                got_bv[k], bytes_in_word(k, eff));
         end
      end
      rx_full = 1'b0;
   endtask

   initial begin
      #1500000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < 64; i++) stream[i] = '0;
      repeat (3) @(negedge clk);
      chk(busy == 1'b0 && todo == 16'd0, "R7", "reset idle", {busy, todo}, 0);
      chk(sclk == 1'b0 && rx_push == 1'b0 && ovf == 1'b0, "R5", "reset outputs",
          {sclk, rx_push, ovf}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      // zero count ignored
      req_wr = 1'b1;
      req_count = 16'd0;
      @(negedge clk);
      req_wr = 1'b0;
      chk(busy == 1'b0 && todo == 16'd0, "R7", "zero count ignored", {busy, todo}, 0);
      // directed corners
      run_xfer(1, 1'b0, 1'b0);    // R4 single byte
      run_xfer(3, 1'b0, 1'b0);    // R4 three bytes
      run_xfer(4, 1'b0, 1'b0);    // R3 exact word
      run_xfer(6, 1'b0, 1'b0);    // R4 full + partial
      run_xfer(32, 1'b0, 1'b0);   // R6 at limit
      run_xfer(1000, 1'b0, 1'b0); // R6 clamp
      run_xfer(8, 1'b0, 1'b1);    // R7 poke while busy
      run_xfer(4, 1'b1, 1'b0);    // R8 overflow drops
      run_xfer(5, 1'b0, 1'b0);    // R8 flag cleared by new request
      for (int t = 0; t < 30; t++) begin
         run_xfer(1 + int'($urandom % 40), 1'b0, 1'b0);
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule